// File: doc/BRIEF.md
# Nibble-Addressable Double-Buffered Converter Code Register

This block is the digital front end of a 12-bit converter. A 12-bit data bus feeds three 4-bit staging nibbles. Each nibble has its own active-low select, and all three share one active-low write strobe. A 12-bit code register sits behind the staging nibbles and holds the value that goes to the converter. It loads only when the strobe and a separate active-low load enable are both low. A host on a narrow bus can therefore build a full word over several writes, and the converter input keeps its old value until the word is complete.

The model is synchronous, but it keeps the level-sensitive feel of a latch chain. While a write is active, each enabled element passes its input straight through to the outputs in the same cycle. On every clock edge where the enable condition holds, the register captures that value. When the strobe, all selects and the load enable are low together, the bus reaches the code output at once. If the load enable is asserted in the same write as the final nibble, the output takes the new nibble together with the nibbles stored earlier. No mixed code is ever shown.

Top module: `dac_word_assembler`

## Requirements
- R1: Select bit 2 governs data bits 11..8, select bit 1 governs bits 7..4, and select bit 0 governs bits 3..0.
- R2: A staging nibble takes its bus slice on a clock edge only when `wr_n` and its select bit are both low. Otherwise it keeps its value.
- R3: When `wr_n` and `load_n` are both low, the code register takes the staged word on the clock edge. The staged word uses bus data for the enabled nibbles and stored data for the others.
- R4: While `wr_n` is high, neither output changes, whatever the selects and `load_n` do.
- R5: With `wr_n`, all selects and `load_n` low, `code_out` equals `data_in` in the same cycle.
- R6: A write that enables both the last nibble and `load_n` puts the new nibble and the earlier stored nibbles on `code_out` together, in that same cycle.
- R7: A synchronous high `rst` clears all staging nibbles and the code register to zero.
- R8: `staged_word` shows the bus slice of each enabled nibble in the cycle the write is active. It shows the stored value for every other nibble.
- R9: Writes to staging nibbles without `load_n` low leave `code_out` unchanged. During a two-write load, `code_out` only ever shows the old word or the complete new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 12 | Data bus |
| wr_n | input | 1 | Write strobe, active low |
| nib_sel_n | input | 3 | Nibble selects, active low, bit 2 = most significant nibble |
| load_n | input | 1 | Code register load enable, active low |
| code_out | output | 12 | Code presented to the converter |
| staged_word | output | 12 | Assembled staging word |

## Verification
A table walks the block through single-nibble writes, one at a time for each select, to show that each select reaches only its own slice and leaves `code_out` alone. It then covers pairs of nibbles, writes with the strobe high and every select asserted, a strobe with nothing selected, a bare load, all-transparent writes with all-ones and all-zeros data, and last-nibble-plus-load writes for each nibble position. Each row is checked in its first cycle, before any edge, which separates the combinational pass-through from the registered value, and again after several edges. A directed two-write load is watched every cycle for a mixed code, and a reset taken from a loaded state confirms both outputs clear.

// File: rtl/dasm_pkg.sv
package dasm_pkg;

  // An element is enabled only while both of its active-low controls are low.
  function automatic logic strobe_hit(input logic strobe_n, input logic en_n);
    return !(strobe_n | en_n);
  endfunction

  // Lowest bit position of nibble idx in a word of w-bit nibbles.
  function automatic int unsigned nib_base(input int unsigned idx, input int unsigned w);
    return idx * w;
  endfunction

endpackage

// File: rtl/dasm_nibble_cell.sv
module dasm_nibble_cell #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             sel_n,
  input  logic [NIB_W-1:0] din,
  output logic [NIB_W-1:0] view,
  output logic             hit
);
  import dasm_pkg::*;

  logic [NIB_W-1:0] held_q;

  assign hit  = strobe_hit(wr_n, sel_n);
  assign view = hit ? din : held_q;

  always_ff @(posedge clk) begin
    if (rst)      held_q <= '0;
    else if (hit) held_q <= din;
  end

  // R2
  nib_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> held_q == $past(held_q));

  // R2
  nib_capture_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> held_q == $past(din));

endmodule

// File: rtl/dasm_out_stage.sv
module dasm_out_stage #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              load_n,
  input  logic [WORD_W-1:0] staged,
  output logic [WORD_W-1:0] code_out,
  output logic              ld_hit
);
  import dasm_pkg::*;

  logic [WORD_W-1:0] code_q;

  assign ld_hit   = strobe_hit(wr_n, load_n);
  assign code_out = ld_hit ? staged : code_q;

  always_ff @(posedge clk) begin
    if (rst)         code_q <= '0;
    else if (ld_hit) code_q <= staged;
  end

  // R3
  out_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_hit |=> code_q == $past(staged));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_hit |=> $stable(code_q));

  // R7
  out_reset_chk: assert property (@(posedge clk)
    rst |=> code_q == '0);

endmodule

// File: rtl/dac_word_assembler.sv
module dac_word_assembler #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned NIB_N = 3,
  localparam int unsigned WORD_W = NIB_W * NIB_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] data_in,
  input  logic              wr_n,
  input  logic [NIB_N-1:0]  nib_sel_n,
  input  logic              load_n,
  output logic [WORD_W-1:0] code_out,
  output logic [WORD_W-1:0] staged_word
);
  import dasm_pkg::*;

  logic [NIB_N-1:0] nib_hit;
  logic             ld_hit;

  // R1: select bit i governs the i-th nibble counted from the least significant end
  for (genvar gi = 0; gi < NIB_N; gi++) begin : g_nib
    localparam int unsigned LO = nib_base(gi, NIB_W);
    dasm_nibble_cell #(.NIB_W(NIB_W)) u_cell (
      .clk   (clk),
      .rst   (rst),
      .wr_n  (wr_n),
      .sel_n (nib_sel_n[gi]),
      .din   (data_in[LO +: NIB_W]),
      .view  (staged_word[LO +: NIB_W]),
      .hit   (nib_hit[gi])
    );

    // R6
    last_nibble_chk: assert property (@(posedge clk) disable iff (rst)
      (nib_hit[gi] && ld_hit) |-> code_out[LO +: NIB_W] == data_in[LO +: NIB_W]);
  end

  dasm_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .wr_n     (wr_n),
    .load_n   (load_n),
    .staged   (staged_word),
    .code_out (code_out),
    .ld_hit   (ld_hit)
  );

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    wr_n ##1 wr_n |-> ($stable(code_out) && $stable(staged_word)));

  // R5
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && nib_sel_n == '0 && !load_n) |-> code_out == data_in);

endmodule

// File: tb/sim_dac_word_assembler.sv
module sim_dac_word_assembler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] data_in = '0;
  logic        wr_n = 1'b1;
  logic [2:0]  nib_sel_n = 3'b111;
  logic        load_n = 1'b1;
  logic [11:0] code_out;
  logic [11:0] staged_word;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dac_word_assembler u0 (
    .clk(clk), .rst(rst), .data_in(data_in), .wr_n(wr_n),
    .nib_sel_n(nib_sel_n), .load_n(load_n),
    .code_out(code_out), .staged_word(staged_word)
  );

  // {data, ctl = {wr_n, sel2_n, sel1_n, sel0_n, load_n}, expected staged, expected code}
  localparam int NROW = 17;
  localparam logic [40:0] VEC [NROW] = '{
    {12'hABC, 5'b11111, 12'h000, 12'h000},
    {12'hABC, 5'b00111, 12'hA00, 12'h000},
    {12'h5DE, 5'b01011, 12'hAD0, 12'h000},
    {12'h123, 5'b01101, 12'hAD3, 12'h000},
    {12'h777, 5'b01110, 12'hAD3, 12'hAD3},
    {12'h777, 5'b11111, 12'hAD3, 12'hAD3},
    {12'h456, 5'b10000, 12'hAD3, 12'hAD3},
    {12'h9F1, 5'b00000, 12'h9F1, 12'h9F1},
    {12'h2B8, 5'b01010, 12'h9B1, 12'h9B1},
    {12'hE00, 5'b00011, 12'hE01, 12'h9B1},
    {12'h06C, 5'b01100, 12'hE0C, 12'hE0C},
    {12'h555, 5'b00110, 12'h50C, 12'h50C},
    {12'hFFF, 5'b01001, 12'h5FF, 12'h50C},
    {12'h000, 5'b01111, 12'h5FF, 12'h50C},
    {12'h000, 5'b01110, 12'h5FF, 12'h5FF},
    {12'hFFF, 5'b00000, 12'hFFF, 12'hFFF},
    {12'h000, 5'b00000, 12'h000, 12'h000}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 5, 6:      return "R4";
      1, 2, 3, 13:  return "R2";
      4, 14:        return "R3";
      7, 15, 16:    return "R5";
      8, 10, 11:    return "R6";
      default:      return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_n = 1'b1; nib_sel_n = 3'b111; load_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R7 reset code", code_out, 12'h000);
    check("R7 reset staged", staged_word, 12'h000);

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      data_in   = VEC[i][40:29];
      wr_n      = VEC[i][28];
      nib_sel_n = VEC[i][27:25];
      load_n    = VEC[i][24];
      #2;
      // first cycle, before any edge: pass-through paths
      check("R8 staged first cycle", staged_word, VEC[i][23:12]);
      check({row_tag(i), " code first cycle"}, code_out, VEC[i][11:0]);
      // strobe held 4 cycles = 80 ns, meeting pulse width and data setup
      repeat (3) @(negedge clk);
      #2;
      check({row_tag(i), " staged settled"}, staged_word, VEC[i][23:12]);
      check({row_tag(i), " code settled"}, code_out, VEC[i][11:0]);
      idle();
    end

    // R9: two-write load, old word 000, new word 3A5, watched every cycle
    @(negedge clk);
    data_in = 12'h0A5; wr_n = 1'b0; nib_sel_n = 3'b100; load_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      #2;
      check("R9 no partial word (first write)", code_out, 12'h000);
      @(negedge clk);
    end
    wr_n = 1'b1; nib_sel_n = 3'b111;
    #2;
    check("R9 code held between writes", code_out, 12'h000);
    @(negedge clk);
    data_in = 12'h300; wr_n = 1'b0; nib_sel_n = 3'b011; load_n = 1'b0;
    for (int c = 0; c < 4; c++) begin
      #2;
      check("R9 R6 whole word with last nibble", code_out, 12'h3A5);
      @(negedge clk);
    end
    wr_n = 1'b1; nib_sel_n = 3'b111; load_n = 1'b1;
    #2;
    check("R9 final word held", code_out, 12'h3A5);
    check("R1 staged after two writes", staged_word, 12'h3A5);

    // R7: reset from a loaded state
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R7 code cleared", code_out, 12'h000);
    check("R7 staged cleared", staged_word, 12'h000);
    // R4 after reset: strobe high with all enables low changes nothing
    nib_sel_n = 3'b000; load_n = 1'b0; data_in = 12'hFFF;
    repeat (2) @(negedge clk);
    #2;
    check("R4 strobe high ignored code", code_out, 12'h000);
    check("R4 strobe high ignored staged", staged_word, 12'h000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule